// File: doc/BRIEF.md
# Indirect Table Read Engine

This block lets a narrow host register port read entries that are far wider than one byte. The host first writes an operation code into a control register, which picks one of four internal tables: static forwarding entries, VLAN entries, learned (dynamic) address entries or per-port statistics counters. It then writes the entry index, high part first. Writing the low index byte starts the read.

The engine then reads the entry over a byte-wide table-memory port, one byte per cycle, starting from the most significant byte. It gathers the bytes in a staging bank. When the last byte arrives, it copies the whole staging bank into nine host-visible data registers in one step.

Each table packs its entry differently, so each one fetches only the bytes that carry its fields. Bytes that are not fetched read back as zero. A busy output marks the fetch window. During that window the data registers keep showing the previous result.

Top module: `itab_access_ctrl`

## Requirements
- R1: Control code 0x10 selects the static table, 0x14 the VLAN table, 0x19 the dynamic table and 0x1C the counter table. These drive `tm_tbl` as 0, 1, 2 and 3 respectively.
- R2: The host registers are control at 0x6C, index-high at 0x6D and index-low at 0x6E.
  - A write to 0x6E while idle, with a known code held in control, starts a read.
  - The index of that read is {index-high[1:0], the byte written to 0x6E}.
  - `busy` and the first memory request appear in the cycle after the write.
- R3: The memory port issues one request per cycle. Each request carries a byte number that is one higher than the previous one, ending at byte 8, where byte 0 holds entry bits 71:64. Read data returns one cycle after its request.
- R4: Data registers 0x70 to 0x78 hold the result. Register 0x70+k holds entry bits (71-8k) down to (64-8k).
- R5: Each table fetches a fixed range of bytes:
  - dynamic: all nine bytes;
  - VLAN: bytes 1 to 8;
  - static: bytes 2 to 8 (bits 55:0, which hold the port map in 52:48 and the address in 47:0);
  - counter: bytes 5 to 8 (bits 31:0).

  Bytes outside the range read as 0.
- R6: `busy` stays high for exactly (10 - first byte) cycles: 10 for dynamic, 9 for VLAN, 8 for static and 5 for counters. The new data is readable from the first cycle in which `busy` is low.
- R7: While `busy` is high, reads of the data registers return the previous result.
- R8: A start with any other control code issues no memory request, leaves `busy` low and leaves the data registers unchanged.
- R9: Host writes to control, index-high or index-low while `busy` is high are ignored. They neither change the readback value nor start another read.
- R10: After reset, `busy` is low, there are no memory requests, and every host register reads 0. Control and index registers read back the last value written to them.
- R11: The dynamic table is addressable over its full 1024 entries, including index 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 8 | Host write register address |
| host_wr_data | input | 8 | Host write data |
| host_rd_addr | input | 8 | Host read register address |
| host_rd_data | output | 8 | Host read data (combinational) |
| busy | output | 1 | Fetch in progress |
| tm_rd_en | output | 1 | Table memory byte read request |
| tm_tbl | output | 2 | Selected table |
| tm_index | output | 10 | Entry index |
| tm_byte | output | 4 | Byte number within the entry, 0 = most significant |
| tm_rdata | input | 8 | Byte returned one cycle after request |

## Verification
A start write is sampled at a clock edge. `busy` and the first request are visible in the cycle that follows. The last byte is captured (9 - first) edges later, and one further edge commits the result. The monitor therefore counts the sampled cycles in which `busy` is high and compares the count with 10 minus the first byte of the selected table. It also counts the requests, expecting 9 minus the first byte. It reads the nine data registers only after `busy` falls. While `busy` is still high, it reads one data register per cycle and expects the previous result.

// File: rtl/itab_pkg.sv
package itab_pkg;
    localparam int NBYTES = 9;
    localparam int BYTE_W = $clog2(NBYTES);

    typedef enum logic [1:0] {
        TBL_STATIC = 2'd0,
        TBL_VLAN   = 2'd1,
        TBL_DYN    = 2'd2,
        TBL_MIB    = 2'd3
    } tbl_e;

    localparam logic [7:0] CODE_STATIC = 8'h10;
    localparam logic [7:0] CODE_VLAN   = 8'h14;
    localparam logic [7:0] CODE_DYN    = 8'h19;
    localparam logic [7:0] CODE_MIB    = 8'h1C;
endpackage

// File: rtl/itab_code_dec.sv
module itab_code_dec
    import itab_pkg::*;
(
    input  logic [7:0]        code,
    output logic              hit,
    output tbl_e              tbl,
    output logic [BYTE_W-1:0] first
);
    always_comb begin
        hit   = 1'b1;
        tbl   = TBL_STATIC;
        first = '0;
        case (code)
            CODE_STATIC: begin tbl = TBL_STATIC; first = BYTE_W'(2); end
            CODE_VLAN:   begin tbl = TBL_VLAN;   first = BYTE_W'(1); end
            CODE_DYN:    begin tbl = TBL_DYN;    first = BYTE_W'(0); end
            CODE_MIB:    begin tbl = TBL_MIB;    first = BYTE_W'(5); end
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/itab_fetch_seq.sv
module itab_fetch_seq
    import itab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] first,
    output logic              busy,
    output logic              rd_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              cap_en,
    output logic [BYTE_W-1:0] cap_byte,
    output logic              done
);
    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(NBYTES - 1);

    typedef struct packed {
        logic              busy;
        logic              req_on;
        logic [BYTE_W-1:0] req_idx;
        logic              cap_vld;
        logic [BYTE_W-1:0] cap_idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy    = 1'b1;
                seq_d.req_on  = 1'b1;
                seq_d.req_idx = first;
                seq_d.cap_vld = 1'b0;
            end
        end else begin
            seq_d.cap_vld = seq_q.req_on;
            seq_d.cap_idx = seq_q.req_idx;
            if (seq_q.req_on) begin
                if (seq_q.req_idx == LAST) seq_d.req_on  = 1'b0;
                else                       seq_d.req_idx = seq_q.req_idx + 1'b1;
            end
            if (seq_q.cap_vld && seq_q.cap_idx == LAST) begin
                done          = 1'b1;
                seq_d.busy    = 1'b0;
                seq_d.cap_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy     = seq_q.busy;
    assign rd_en    = seq_q.req_on;
    assign rd_byte  = seq_q.req_idx;
    assign cap_en   = seq_q.cap_vld;
    assign cap_byte = seq_q.cap_idx;
endmodule

// File: rtl/itab_byte_bank.sv
module itab_byte_bank
    import itab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_en,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic [7:0]        cap_data,
    input  logic              commit,
    input  logic [BYTE_W-1:0] rd_idx,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        logic [NBYTES-1:0][7:0] stage;
        logic [NBYTES-1:0][7:0] vis;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clear) bank_d.stage = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (cap_en && cap_byte == BYTE_W'(k)) bank_d.stage[k] = cap_data;
        end
        if (commit) bank_d.vis = bank_d.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (rd_idx == BYTE_W'(k)) rd_data = bank_q.vis[k];
        end
    end
endmodule

// File: rtl/itab_access_ctrl.sv
module itab_access_ctrl
    import itab_pkg::*;
#(
    parameter int         IDX_W     = 10,
    parameter logic [7:0] REG_CTRL  = 8'h6C,
    parameter logic [7:0] REG_AHI   = 8'h6D,
    parameter logic [7:0] REG_ALO   = 8'h6E,
    parameter logic [7:0] DATA_BASE = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [7:0]        host_wr_addr,
    input  logic [7:0]        host_wr_data,
    input  logic [7:0]        host_rd_addr,
    output logic [7:0]        host_rd_data,
    output logic              busy,
    output logic              tm_rd_en,
    output logic [1:0]        tm_tbl,
    output logic [IDX_W-1:0]  tm_index,
    output logic [BYTE_W-1:0] tm_byte,
    input  logic [7:0]        tm_rdata
);
    localparam int         HI_W      = IDX_W - 8;
    localparam logic [7:0] DATA_LAST = DATA_BASE + 8'(NBYTES - 1);

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [7:0]       ahi;
        logic [7:0]       alo;
        tbl_e             tbl;
        logic [IDX_W-1:0] idx;
    } host_t;

    host_t ctrl_d, ctrl_q;

    logic              code_hit;
    tbl_e              code_tbl;
    logic [BYTE_W-1:0] code_first;
    logic              go;
    logic              cap_en, done;
    logic [BYTE_W-1:0] cap_byte;
    logic [7:0]        bank_rd;
    logic              rd_in_bank;
    logic [BYTE_W-1:0] bank_idx;

    itab_code_dec u_dec (
        .code  (ctrl_q.ctrl),
        .hit   (code_hit),
        .tbl   (code_tbl),
        .first (code_first)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        go     = 1'b0;
        if (host_wr_en && !busy) begin
            if (host_wr_addr == REG_CTRL) ctrl_d.ctrl = host_wr_data;
            if (host_wr_addr == REG_AHI)  ctrl_d.ahi  = host_wr_data;
            if (host_wr_addr == REG_ALO) begin
                ctrl_d.alo = host_wr_data;
                if (code_hit) begin
                    go         = 1'b1;
                    ctrl_d.tbl = code_tbl;
                    ctrl_d.idx = {ctrl_q.ahi[HI_W-1:0], host_wr_data};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    itab_fetch_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go),
        .first    (code_first),
        .busy     (busy),
        .rd_en    (tm_rd_en),
        .rd_byte  (tm_byte),
        .cap_en   (cap_en),
        .cap_byte (cap_byte),
        .done     (done)
    );

    assign rd_in_bank = (host_rd_addr >= DATA_BASE) && (host_rd_addr <= DATA_LAST);
    assign bank_idx   = BYTE_W'(host_rd_addr - DATA_BASE);

    itab_byte_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (go),
        .cap_en   (cap_en),
        .cap_byte (cap_byte),
        .cap_data (tm_rdata),
        .commit   (done),
        .rd_idx   (bank_idx),
        .rd_data  (bank_rd)
    );

    always_comb begin
        host_rd_data = '0;
        if (rd_in_bank)                    host_rd_data = bank_rd;
        else if (host_rd_addr == REG_CTRL) host_rd_data = ctrl_q.ctrl;
        else if (host_rd_addr == REG_AHI)  host_rd_data = ctrl_q.ahi;
        else if (host_rd_addr == REG_ALO)  host_rd_data = ctrl_q.alo;
    end

    assign tm_tbl   = ctrl_q.tbl;
    assign tm_index = ctrl_q.idx;
endmodule

// File: rtl/itab_access_ctrl_chk.sv
module itab_access_ctrl_chk
    import itab_pkg::*;
#(
    parameter int         IDX_W     = 10,
    parameter logic [7:0] REG_ALO   = 8'h6E,
    parameter logic [7:0] DATA_BASE = 8'h70
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic [7:0]        host_wr_addr,
    input logic [7:0]        host_rd_addr,
    input logic [7:0]        host_rd_data,
    input logic              busy,
    input logic              tm_rd_en,
    input logic [1:0]        tm_tbl,
    input logic [IDX_W-1:0]  tm_index,
    input logic [BYTE_W-1:0] tm_byte,
    input logic [7:0]        ctrl_code
);
    logic known, lo_wr, in_data;
    assign known   = (ctrl_code == CODE_STATIC) || (ctrl_code == CODE_VLAN) ||
                     (ctrl_code == CODE_DYN)    || (ctrl_code == CODE_MIB);
    assign lo_wr   = host_wr_en && (host_wr_addr == REG_ALO) && !busy;
    assign in_data = (host_rd_addr >= DATA_BASE) && (host_rd_addr < DATA_BASE + 8'(NBYTES));

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tm_rd_en |-> busy); // R3
    AST_BYTE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        tm_rd_en && $past(tm_rd_en) |-> tm_byte == $past(tm_byte) + 1'b1); // R3
    AST_LAST_BYTE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        tm_rd_en && tm_byte == BYTE_W'(NBYTES - 1) |=> !tm_rd_en); // R3
    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tm_rd_en && $past(tm_rd_en) |-> $stable(tm_index) && $stable(tm_tbl)); // R2
    AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr && known |=> busy && tm_rd_en); // R2
    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr && !known |=> !busy && !tm_rd_en); // R8
    AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && $stable(host_rd_addr) && in_data |-> $stable(host_rd_data)); // R7
endmodule

bind itab_access_ctrl itab_access_ctrl_chk #(
    .IDX_W(IDX_W), .REG_ALO(REG_ALO), .DATA_BASE(DATA_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_addr (host_wr_addr),
    .host_rd_addr (host_rd_addr),
    .host_rd_data (host_rd_data),
    .busy         (busy),
    .tm_rd_en     (tm_rd_en),
    .tm_tbl       (tm_tbl),
    .tm_index     (tm_index),
    .tm_byte      (tm_byte),
    .ctrl_code    (ctrl_q.ctrl)
);

// File: tb/itab_access_ctrl_bench.sv
module itab_access_ctrl_bench;
    localparam int CLK_PERIOD = 20;
    localparam logic [7:0] A_CTRL = 8'h6C, A_AHI = 8'h6D, A_ALO = 8'h6E, A_DATA = 8'h70;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr_en = 1'b0;
    logic [7:0] host_wr_addr = '0, host_wr_data = '0, host_rd_addr = A_DATA, host_rd_data;
    logic busy, tm_rd_en;
    logic [1:0] tm_tbl;
    logic [9:0] tm_index;
    logic [3:0] tm_byte;
    logic [7:0] tm_rdata = '0;

    int n_chk = 0, n_fail = 0, busy_cnt = 0, rd_cnt = 0, cur = 0;
    logic [71:0] vis_sh = '0;

    typedef struct {
        logic [71:0] bytes;
        int          lat;
        int          nreq;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    itab_access_ctrl u_itab_access_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .busy(busy), .tm_rd_en(tm_rd_en), .tm_tbl(tm_tbl), .tm_index(tm_index),
        .tm_byte(tm_byte), .tm_rdata(tm_rdata)
    );

    function automatic logic [71:0] entry(input logic [1:0] t, input logic [9:0] i);
        case (t)
            2'd0:    entry = {19'h7FFFF, 5'(i * 3 + 1), 48'h0010A0000000 | 48'(i)};
            2'd1:    entry = {8'hEE, 24'h0, 20'(i * 13), 20'(i ^ 10'h155)};
            2'd2:    entry = {i[0], 10'h0, i[2:1], i[5:3], i[6], 7'(i), 48'h02BEEF000000 | 48'(i)};
            default: entry = {40'hFF_FFFF_FFFF, 32'(i * 1000 + 7)};
        endcase
    endfunction

    function automatic int first_of(input logic [1:0] t);
        case (t)
            2'd0: first_of = 2;
            2'd1: first_of = 1;
            2'd2: first_of = 0;
            default: first_of = 5;
        endcase
    endfunction

    always @(posedge clk) begin
        if (tm_rd_en) begin
            logic [71:0] e;
            e = entry(tm_tbl, tm_index);
            tm_rdata <= e[71 - 8 * int'(tm_byte) -: 8];
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic push_exp(input logic [1:0] t, input logic [9:0] i, input string tag);
        exp_t x;
        int f;
        f = first_of(t);
        x.bytes = entry(t, i);
        for (int k = 0; k < f; k++) x.bytes[71 - 8 * k -: 8] = 8'h00;
        x.lat = 10 - f; x.nreq = 9 - f; x.tag = tag;
        sbq.push_back(x);
    endtask

    task automatic access(input logic [7:0] code, input logic [1:0] t, input logic [9:0] i,
                          input string tag);
        hw(A_CTRL, code);
        hw(A_AHI, {6'h0, i[9:8]});
        push_exp(t, i, tag);
        hw(A_ALO, i[7:0]);
        chk("R2 busy after start", 72'(busy), 72'(1));
        wait (sbq.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected results when busy falls
    always begin
        @(negedge clk);
        if (busy) begin
            busy_cnt++;
            chk("R7 data held while busy", 72'(host_rd_data), 72'(vis_sh[71 - 8 * cur -: 8]));
            cur = (cur + 1) % 9;
            host_rd_addr = A_DATA + 8'(cur);
        end else if (busy_cnt > 0) begin
            if (sbq.size() == 0) begin
                chk("R9 unexpected fetch", 72'(busy_cnt), 72'(0));
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R6 busy length", 72'(busy_cnt), 72'(e.lat));
                chk("R3 request count", 72'(rd_cnt), 72'(e.nreq));
                for (int k = 0; k < 9; k++) begin
                    host_rd_addr = A_DATA + 8'(k);
                    #1;
                    chk(e.tag, 72'(host_rd_data), 72'(e.bytes[71 - 8 * k -: 8]));
                end
                vis_sh = e.bytes;
            end
            busy_cnt = 0; rd_cnt = 0; cur = 0;
            host_rd_addr = A_DATA;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy reset", 72'(busy), 72'(0));
        chk("R10 no request", 72'(tm_rd_en), 72'(0));
        for (int k = 0; k < 9; k++) begin
            host_rd_addr = A_DATA + 8'(k); #1;
            chk("R10 data zero", 72'(host_rd_data), 72'(0));
        end
        host_rd_addr = A_CTRL; #1;
        chk("R10 ctrl zero", 72'(host_rd_data), 72'(0));
        host_rd_addr = A_DATA;

        // R1 R4 R5: each table and its byte range
        access(8'h10, 2'd0, 10'h001, "R5 static bytes");
        access(8'h10, 2'd0, 10'h2A5, "R1 static table");
        access(8'h14, 2'd1, 10'h010, "R5 vlan bytes");
        access(8'h19, 2'd2, 10'h000, "R4 dyn byte order");
        access(8'h19, 2'd2, 10'h3FF, "R11 dyn top index");
        access(8'h1C, 2'd3, 10'h02E, "R5 counter bytes");
        access(8'h19, 2'd2, 10'h05B, "R4 dyn fields");

        // R8 unknown code
        hw(A_CTRL, 8'h11);
        hw(A_ALO, 8'h02);
        repeat (3) @(negedge clk);
        chk("R8 busy stays low", 72'(busy), 72'(0));
        chk("R8 no memory request", 72'(rd_cnt), 72'(0));
        for (int k = 0; k < 9; k++) begin
            host_rd_addr = A_DATA + 8'(k); #1;
            chk("R8 data unchanged", 72'(host_rd_data), 72'(vis_sh[71 - 8 * k -: 8]));
        end
        host_rd_addr = A_DATA;

        // R9 writes during busy ignored
        hw(A_CTRL, 8'h19);
        hw(A_AHI, 8'h01);
        push_exp(2'd2, 10'h155, "R9 original fetch intact");
        hw(A_ALO, 8'h55);
        hw(A_CTRL, 8'h1C);
        hw(A_AHI, 8'h03);
        hw(A_ALO, 8'h00);
        wait (sbq.size() == 0);
        repeat (4) @(negedge clk);
        host_rd_addr = A_CTRL; #1;
        chk("R9 ctrl unchanged", 72'(host_rd_data), 72'(8'h19));
        host_rd_addr = A_AHI; #1;
        chk("R9 index-high unchanged", 72'(host_rd_data), 72'(8'h01));
        host_rd_addr = A_ALO; #1;
        chk("R10 index-low readback", 72'(host_rd_data), 72'(8'h55));
        host_rd_addr = A_DATA;

        access(8'h14, 2'd1, 10'h3C3, "R1 vlan table");
        access(8'h1C, 2'd3, 10'h1FF, "R1 counter table");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule